// File: doc/BRIEF.md
# Strobe-Loaded XOR Cipher Registers

This block keeps two byte-wide registers, a plaintext register and a key register, and presents their bitwise XOR on a registered output port. Both registers take their value from one shared input bus. The load is triggered by a strobe line that arrives from outside the clock domain. The strobe is passed through a multi-flop synchronizer and its rising edge is detected. A select line, sampled with the same delay, decides which register takes the bus value.

The strobe and the select sit on a group of general-purpose pins that the block uses only as inputs. The block therefore ties the output values and the output enables of that group to zero. A synchronous active-low reset clears both registers and the edge history. A host loads the plaintext with select low, then loads the key with select high, and reads the enciphered byte from the output.

Top module: `xcr_cipher_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both registers and the output clear to 8'h00. The output stays 8'h00 until a load occurs.
- R2: At a detected strobe edge with select (pin 1) at 0, the bus value is written to the plaintext register and the key register keeps its value.
- R3: At a detected strobe edge with select (pin 1) at 1, the bus value is written to the key register and the plaintext register keeps its value.
- R4: `xor_out` equals plaintext XOR key. Plaintext 8'hAA with key 8'hFF gives 8'h55.
- R5: Each 0-to-1 transition of the strobe (pin 0) causes exactly one load. Holding the strobe high causes no further load, even if the bus changes during that time.
- R6: Strobe, select and bus pass through the same two synchronizer stages. The registers load on the third rising clock edge after the strobe is driven high. `xor_out` shows the new value after the fourth edge and still shows the old value after the third.
- R7: The edge history clears on reset. A strobe that is already high when reset is released counts as one edge and causes one load.
- R8: `pins_out` and `pins_oe` are always 8'h00. Pins 2 to 7 of `pins_in` have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_in | input | 8 | Shared load value for the plaintext or key register |
| pins_in | input | 8 | Input-only pin group: bit 0 is the load strobe, bit 1 is the select |
| xor_out | output | 8 | Registered plaintext XOR key |
| pins_out | output | 8 | Output values of the pin group, tied to zero |
| pins_oe | output | 8 | Output enables of the pin group, tied to zero |

## Verification
The assertions assume that the bus and the select stay stable from the moment the strobe rises until the load has happened. Otherwise the synchronized copies could straddle the edge and the assertions would still hold while the captured value is undefined. The bench changes the bus and the select only on falling clock edges while the strobe is low. It holds them for several cycles past each rising strobe. It changes the bus during a held-high strobe only after the load has already fired.

// File: rtl/xcr_pkg.sv
package xcr_pkg;
  // Which register a detected strobe edge writes.
  typedef enum logic {
    TGT_PLAIN = 1'b0,
    TGT_KEY   = 1'b1
  } xcr_target_e;
endpackage

// File: rtl/xcr_sync.sv
module xcr_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[g] <= '0;
          else        stage_q[g] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[g] <= '0;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/xcr_edge.sv
module xcr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);
  logic hist_q;

  always_ff @(posedge clk) begin
    if (!rst_n) hist_q <= 1'b0;
    else        hist_q <= level;
  end

  assign rise = level & ~hist_q;
endmodule

// File: rtl/xcr_regs.sv
module xcr_regs
  import xcr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  xcr_target_e       target,
  input  logic [DATA_W-1:0] value,
  output logic [DATA_W-1:0] plain_q,
  output logic [DATA_W-1:0] key_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      plain_q <= '0;
      key_q   <= '0;
    end else if (load) begin
      if (target == TGT_KEY) key_q   <= value;
      else                   plain_q <= value;
    end
  end
endmodule

// File: rtl/xcr_cipher_top.sv
module xcr_cipher_top
  import xcr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PIN_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int STB_BIT     = 0,
  parameter int SEL_BIT     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus_in,
  input  logic [PIN_W-1:0]  pins_in,
  output logic [DATA_W-1:0] xor_out,
  output logic [PIN_W-1:0]  pins_out,
  output logic [PIN_W-1:0]  pins_oe
);
  localparam int SYNC_W = DATA_W + 2;

  logic [SYNC_W-1:0] raw_vec;
  logic [SYNC_W-1:0] sync_vec;
  logic              stb_s;
  logic              sel_s;
  logic [DATA_W-1:0] bus_s;
  logic              load_p;
  logic [DATA_W-1:0] plain_q;
  logic [DATA_W-1:0] key_q;
  logic              unused_pins;

  // Strobe, select and bus share one synchronizer so they stay aligned.
  assign raw_vec = {pins_in[SEL_BIT], bus_in, pins_in[STB_BIT]};

  xcr_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (raw_vec),
    .d_out (sync_vec)
  );

  assign stb_s = sync_vec[0];
  assign bus_s = sync_vec[DATA_W:1];
  assign sel_s = sync_vec[SYNC_W-1];

  xcr_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (stb_s),
    .rise  (load_p)
  );

  xcr_regs #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_p),
    .target  (xcr_target_e'(sel_s)),
    .value   (bus_s),
    .plain_q (plain_q),
    .key_q   (key_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) xor_out <= '0;
    else        xor_out <= plain_q ^ key_q;
  end

  // Pin group is input-only.
  assign pins_out = '0;
  assign pins_oe  = '0;

  // Pins other than strobe and select carry no function.
  assign unused_pins = ^pins_in;
endmodule

// File: rtl/xcr_cipher_chk.sv
module xcr_cipher_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load,
  input logic              sel,
  input logic [DATA_W-1:0] plain_q,
  input logic [DATA_W-1:0] key_q
);
  // R1: reset clears both registers
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (plain_q == '0 && key_q == '0));

  // R2: a plaintext load leaves the key alone
  a_r2_key_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !sel) |=> $stable(key_q));

  // R3: a key load leaves the plaintext alone
  a_r3_plain_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (load && sel) |=> $stable(plain_q));

  // R5: one strobe edge gives a single-cycle load pulse
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !load);

  // R5: without a load pulse neither register moves
  a_r5_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(plain_q) && $stable(key_q)));
endmodule

bind xcr_cipher_top xcr_cipher_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .load    (load_p),
  .sel     (sel_s),
  .plain_q (plain_q),
  .key_q   (key_q)
);

// File: tb/xcr_cipher_top_tb_top.sv
module xcr_cipher_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_in = 8'h00;
  logic [7:0] pins_in = 8'h00;
  logic [7:0] xor_out;
  logic [7:0] pins_out;
  logic [7:0] pins_oe;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_plain = 8'h00;
  logic [7:0] exp_key   = 8'h00;

  always #4 clk = ~clk;

  xcr_cipher_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .pins_in(pins_in),
    .xor_out(xor_out), .pins_out(pins_out), .pins_oe(pins_oe)
  );

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Pulse the strobe with the given select and value, and release it afterwards.
  task automatic do_load(input logic sel, input logic [7:0] v);
    @(negedge clk);
    bus_in = v;
    pins_in[1] = sel;
    pins_in[0] = 1'b1;
    idle(5);
    pins_in[0] = 1'b0;
    idle(4);
    if (sel) exp_key = v; else exp_plain = v;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    idle(3);
    check8("R1", xor_out, 8'h00);
    rst_n = 1'b1;
    idle(3);
    check8("R1", xor_out, 8'h00);
    exp_plain = 8'h00; exp_key = 8'h00;
  endtask

  task automatic t_plain_then_key;
    do_load(1'b0, 8'hAA);
    check8("R2", xor_out, 8'hAA);
    do_load(1'b1, 8'hFF);
    check8("R4", xor_out, 8'h55);
    do_load(1'b0, 8'h0F);
    check8("R2", xor_out, 8'hF0);
    do_load(1'b1, 8'h3C);
    check8("R3", xor_out, 8'h33);
    do_load(1'b1, 8'h00);
    check8("R3", xor_out, 8'h0F);
  endtask

  task automatic t_latency;
    @(negedge clk);
    bus_in = 8'hC3; pins_in[1] = 1'b0; pins_in[0] = 1'b1;
    idle(3);
    check8("R6", xor_out, exp_plain ^ exp_key);
    idle(1);
    exp_plain = 8'hC3;
    check8("R6", xor_out, exp_plain ^ exp_key);
    pins_in[0] = 1'b0;
    idle(4);
  endtask

  task automatic t_hold_high;
    @(negedge clk);
    bus_in = 8'h11; pins_in[1] = 1'b0; pins_in[0] = 1'b1;
    idle(6);
    exp_plain = 8'h11;
    check8("R5", xor_out, exp_plain ^ exp_key);
    bus_in = 8'h99; pins_in[1] = 1'b1;
    idle(8);
    check8("R5", xor_out, exp_plain ^ exp_key);
    pins_in[0] = 1'b0;
    idle(4);
    check8("R5", xor_out, exp_plain ^ exp_key);
  endtask

  task automatic t_pins;
    check8("R8", pins_out, 8'h00);
    check8("R8", pins_oe, 8'h00);
    for (int k = 2; k < 8; k++) begin
      @(negedge clk);
      bus_in = 8'h77;
      pins_in[k] = 1'b1;
      idle(2);
      pins_in[k] = 1'b0;
    end
    idle(5);
    check8("R8", xor_out, exp_plain ^ exp_key);
    check8("R8", pins_oe, 8'h00);
    check8("R8", pins_out, 8'h00);
  endtask

  task automatic t_strobe_at_reset;
    @(negedge clk);
    rst_n = 1'b0;
    bus_in = 8'h5A; pins_in[1] = 1'b1; pins_in[0] = 1'b1;
    idle(3);
    check8("R1", xor_out, 8'h00);
    rst_n = 1'b1;
    idle(6);
    check8("R7", xor_out, 8'h5A);
    pins_in[0] = 1'b0;
    idle(4);
    exp_plain = 8'h00; exp_key = 8'h5A;
    check8("R7", xor_out, 8'h5A);
  endtask

  initial begin
    t_reset();
    t_plain_then_key();
    t_latency();
    t_hold_high();
    t_pins();
    t_strobe_at_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule